// File: doc/BRIEF.md
# Debounced Wake-Up Source Controller

This block decides when the core supply of a low-power chip must be woken. It runs on the slow always-on clock and watches four kinds of wake source: an active-low force-wake pin, a brownout alarm, a real-time-clock alarm, and a vector of general wake-up inputs. Each source has its own enable held in a single mode register. The force-wake pin and the general inputs are each filtered by a debounce counter whose minimum active time comes from a code in the same register.

When any enabled source qualifies, the block raises one wake request level toward the power sequencer. The request stays high until the sequencer returns a one-cycle acknowledge. The analog brownout detector, the RTC and the power switches sit outside and appear here only as plain pins.

Top module: `wake_src_ctrl`

## Requirements
- R1: After reset the mode register reads all zeros, so every source is disabled and both debounce codes select immediate detection, and `wake_req` is low.
- R2: A write (`cfg_we` high) loads `cfg_wdata` into the mode register, and `cfg_rdata` shows the new value after that clock edge. Field layout: bit 0 force-wake enable, bit 1 brownout enable, bit 2 RTC enable, bits 5:3 force-wake debounce code, bits 7:6 wake-input debounce code, bits 8 and up the per-input enable mask (bit 8+i enables `wkup_in[i]`).
- R3: With the force-wake enable at 0 the `force_wake_n` pin has no effect. With it at 1, the pin held low for the selected time qualifies a wake.
- R4: Force-wake codes 0, 1, 2, 3, 4 and 5 need 1, 3, 32, 512, 4096 and 32768 consecutive low samples. Code 0 therefore means a single low sample is enough.
- R5: Force-wake codes 6 and 7 are reserved and behave as 32768 samples.
- R6: Wake-input codes 0, 1 and 2 need 1, 3 and 32 consecutive active samples. The reserved code 3 behaves as 32.
- R7: Each general input has its own debounce counter. The group qualifies when any input whose mask bit is 1 stays high for the selected time. Inputs whose mask bit is 0 are ignored.
- R8: With the brownout enable at 1, a sampled high `bod_alarm` qualifies at once. With it at 0 the alarm is ignored.
- R9: With the RTC enable at 1, a sampled high `rtc_alarm` qualifies at once. With it at 0 the alarm is ignored.
- R10: A debounce counter restarts from zero whenever its input is inactive on a sampled edge before the threshold has been reached.
- R11: A register write clears both debounce counters, so counting starts again on the edge after the write.
- R12: `wake_req` stays high until `wake_ack` is sampled high, and is low after that edge. If a source is still qualified, the request rises again on the following edge.
- R13: A debounced source qualifies on the edge of its N-th consecutive active sample, and `wake_req` rises on the next edge. Brownout and RTC alarms raise `wake_req` on the edge at which they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8+N_WKUP | Mode register write data |
| cfg_rdata | output | 8+N_WKUP | Mode register contents |
| force_wake_n | input | 1 | Active-low force-wake pin |
| bod_alarm | input | 1 | Brownout alarm, active high |
| rtc_alarm | input | 1 | RTC alarm, active high |
| wkup_in | input | N_WKUP | General wake-up inputs, active high |
| wake_ack | input | 1 | One-cycle acknowledge that clears the request |
| wake_req | output | 1 | Core-supply wake request level |

## Verification
The assertions assume that every input is already synchronous to the slow clock and that `wake_ack` is a single-cycle pulse issued by the power sequencer. They also assume that enables are only changed through the write port, so a cleared enable set always matches cleared counters. The stimulus changes every input only on the falling clock edge, holds `wake_ack` high for exactly one cycle, and removes each source before acknowledging whenever a clean return to idle is wanted. Sources are deliberately held through an acknowledge only to exercise the re-assert path.

// File: rtl/wake_pkg.sv
// Package wake_pkg
// Shared field layout and threshold decoding for the wake-source controller.
// Assumes the control fields occupy the low byte of the mode register and the
// per-input enable mask sits directly above them.
package wake_pkg;

    localparam int FW_CODE_W = 3;
    localparam int WK_CODE_W = 2;
    localparam int FW_CNT_W  = 16;
    localparam int WK_CNT_W  = 6;

    // Control part of the mode register; force_en is bit 0.
    typedef struct packed {
        logic [WK_CODE_W-1:0] wk_code;
        logic [FW_CODE_W-1:0] fw_code;
        logic                 rtc_en;
        logic                 bod_en;
        logic                 force_en;
    } wake_ctl_t;

    localparam int CTL_W = $bits(wake_ctl_t);

    // Minimum consecutive low samples for the force-wake pin.
    function automatic logic [FW_CNT_W-1:0] fw_limit(input logic [FW_CODE_W-1:0] code);
        logic [FW_CNT_W-1:0] lim;
        case (code)
            3'd0:    lim = FW_CNT_W'(1);
            3'd1:    lim = FW_CNT_W'(3);
            3'd2:    lim = FW_CNT_W'(32);
            3'd3:    lim = FW_CNT_W'(512);
            3'd4:    lim = FW_CNT_W'(4096);
            default: lim = FW_CNT_W'(32768);
        endcase
        return lim;
    endfunction

    // Minimum consecutive active samples for a general wake input.
    function automatic logic [WK_CNT_W-1:0] wk_limit(input logic [WK_CODE_W-1:0] code);
        logic [WK_CNT_W-1:0] lim;
        case (code)
            2'd0:    lim = WK_CNT_W'(1);
            2'd1:    lim = WK_CNT_W'(3);
            default: lim = WK_CNT_W'(32);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/wake_mode_reg.sv
// Module wake_mode_reg
// Holds the read-write mode register. Assumes writes are single-cycle strobes
// synchronous to the slow clock; the contents are visible on q after the edge.
module wake_mode_reg #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    // Load the register on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/wake_debounce.sv
// Module wake_debounce
// Counts consecutive active samples and flags qualification on the edge where
// the count reaches limit. Assumes limit only changes together with clr.
module wake_debounce #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             qual
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;
    logic             reach;

    // Next count and threshold comparison, one bit wider to avoid wrap.
    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        reach   = (cnt_inc >= {1'b0, limit});
    end

    // Advance, saturate or restart the counter and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !active) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else begin
            cnt  <= reach ? limit : cnt_inc[CNT_W-1:0];
            qual <= reach;
        end
    end

endmodule

// File: rtl/wake_req_latch.sv
// Module wake_req_latch
// Sticky wake request: set by any qualified source, cleared by acknowledge.
// Assumes ack is a single-cycle pulse; acknowledge wins over a set.
module wake_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic req
);

    // Hold the request until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n || ack) begin
            req <= 1'b0;
        end else begin
            req <= req | set;
        end
    end

endmodule

// File: rtl/wake_src_ctrl.sv
// Module wake_src_ctrl
// Wake-up decision unit on the slow clock: gates four source kinds with their
// enables, debounces the force-wake pin and each general input, and drives one
// sticky wake request. Assumes all inputs are synchronous to clk_slow.
module wake_src_ctrl
    import wake_pkg::*;
#(
    parameter  int N_WKUP = 8,
    localparam int REG_W  = CTL_W + N_WKUP
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              force_wake_n,
    input  logic              bod_alarm,
    input  logic              rtc_alarm,
    input  logic [N_WKUP-1:0] wkup_in,
    input  logic              wake_ack,
    output logic              wake_req
);

    logic [REG_W-1:0]    mode_q;
    wake_ctl_t           ctl;
    logic [N_WKUP-1:0]   wk_mask;
    logic [N_WKUP-1:0]   wk_qual;
    logic                fw_qual;
    logic                any_set;

    // Mode register storage.
    wake_mode_reg #(.REG_W(REG_W)) i_mode (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (mode_q)
    );

    // Split the register into control fields and the input mask.
    always_comb begin
        ctl       = wake_ctl_t'(mode_q[CTL_W-1:0]);
        wk_mask   = mode_q[REG_W-1:CTL_W];
        cfg_rdata = mode_q;
    end

    // Force-wake pin debounce, counting low samples while enabled.
    wake_debounce #(.CNT_W(FW_CNT_W)) i_fw_deb (
        .clk    (clk_slow),
        .rst_n  (rst_n),
        .clr    (cfg_we),
        .active (ctl.force_en & ~force_wake_n),
        .limit  (fw_limit(ctl.fw_code)),
        .qual   (fw_qual)
    );

    // One debounce counter per general wake input.
    for (genvar gi = 0; gi < N_WKUP; gi++) begin : g_wk
        wake_debounce #(.CNT_W(WK_CNT_W)) i_wk_deb (
            .clk    (clk_slow),
            .rst_n  (rst_n),
            .clr    (cfg_we),
            .active (wk_mask[gi] & wkup_in[gi]),
            .limit  (wk_limit(ctl.wk_code)),
            .qual   (wk_qual[gi])
        );
    end

    // Combine every qualified or enabled immediate source.
    always_comb begin
        any_set = fw_qual
                | (|wk_qual)
                | (ctl.bod_en & bod_alarm)
                | (ctl.rtc_en & rtc_alarm);
    end

    // Sticky request toward the power sequencer.
    wake_req_latch i_req (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .set   (any_set),
        .ack   (wake_ack),
        .req   (wake_req)
    );

endmodule

// File: rtl/wake_src_ctrl_chk.sv
// Module wake_src_ctrl_chk
// Temporal checks on the controller's ports, attached by bind.
// Assumes wake_ack is a one-cycle pulse and inputs are clk_slow synchronous.
module wake_src_ctrl_chk #(
    parameter  int N_WKUP = 8,
    localparam int REG_W  = 8 + N_WKUP
) (
    input logic              clk_slow,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              bod_alarm,
    input logic              rtc_alarm,
    input logic              wake_ack,
    input logic              wake_req
);

    // R2
    cfg_write_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    // R12
    ack_clear_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wake_ack |=> !wake_req);

    // R12
    req_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (wake_req && !wake_ack) |=> wake_req);

    // R8
    bod_wake_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (bod_alarm && cfg_rdata[1] && !wake_ack) |=> wake_req);

    // R9
    rtc_wake_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (rtc_alarm && cfg_rdata[2] && !wake_ack) |=> wake_req);

    // R3
    all_off_quiet_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (!wake_req && (cfg_rdata[2:0] == 3'b000) && (cfg_rdata[REG_W-1:8] == '0))
        |=> !wake_req);

endmodule

bind wake_src_ctrl wake_src_ctrl_chk #(.N_WKUP(N_WKUP)) i_chk (
    .clk_slow  (clk_slow),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .bod_alarm (bod_alarm),
    .rtc_alarm (rtc_alarm),
    .wake_ack  (wake_ack),
    .wake_req  (wake_req)
);

// File: tb/test_wake_src_ctrl.sv
module test_wake_src_ctrl;

    localparam int NW = 8;
    localparam int RW = 8 + NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          force_wake_n = 1'b1;
    logic          bod_alarm = 1'b0;
    logic          rtc_alarm = 1'b0;
    logic [NW-1:0] wkup_in = '0;
    logic          wake_ack = 1'b0;
    logic          wake_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string rid;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    wake_src_ctrl #(.N_WKUP(NW)) i_wake_src_ctrl (
        .clk_slow     (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .force_wake_n (force_wake_n),
        .bod_alarm    (bod_alarm),
        .rtc_alarm    (rtc_alarm),
        .wkup_in      (wkup_in),
        .wake_ack     (wake_ack),
        .wake_req     (wake_req)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string rid, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rid, act, exp);
        end
    endtask

    task automatic expect_req(int at, logic val, string rid);
        item_t it;
        it.at = at; it.val = val; it.rid = rid;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the request level just after each rising edge.
    always begin : monitor
        item_t it;
        @(posedge clk);
        #2;
        cyc++;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            it = sb_q.pop_front();
            chk((it.at == cyc) && (wake_req === it.val), it.rid,
                {31'd0, wake_req}, {31'd0, it.val});
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [RW-1:0] mk_cfg(bit fe, bit be, bit re,
                                             logic [2:0] fwc, logic [1:0] wkc,
                                             logic [NW-1:0] mask);
        return {mask, wkc, fwc, re, be, fe};
    endfunction

    task automatic write_cfg(logic [RW-1:0] val);
        cfg_we = 1'b1;
        cfg_wdata = val;
        step();
        cfg_we = 1'b0;
        chk(cfg_rdata == val, "R2", 32'(cfg_rdata), 32'(val));
    endtask

    task automatic ack_clear(string rid);
        int n = cyc;
        wake_ack = 1'b1;
        expect_req(n + 1, 1'b0, rid);
        expect_req(n + 2, 1'b0, rid);
        step();
        wake_ack = 1'b0;
        step();
        step();
    endtask

    // sel 0: force-wake pin; sel 1: general inputs with the given pattern.
    task automatic src_test(int sel, logic [NW-1:0] pat, int len, int thr, string rid);
        int n = cyc;
        if (sel == 0) force_wake_n = 1'b0; else wkup_in = pat;
        if (len >= thr) begin
            expect_req(n + thr, 1'b0, rid);
            expect_req(n + thr + 1, 1'b1, rid);
            expect_req(n + len + 2, 1'b1, "R12");
        end else begin
            for (int k = 1; k <= len + 2; k++) expect_req(n + k, 1'b0, rid);
        end
        repeat (len) step();
        force_wake_n = 1'b1;
        wkup_in = '0;
        step();
        step();
        if (len >= thr) ack_clear("R12");
    endtask

    initial begin
        int n;
        int m;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(cfg_rdata == '0, "R1", 32'(cfg_rdata), 0);
        chk(wake_req == 1'b0, "R1", {31'd0, wake_req}, 0);

        // All sources active while everything is disabled (R3 R8 R9 R7).
        n = cyc;
        force_wake_n = 1'b0; bod_alarm = 1'b1; rtc_alarm = 1'b1; wkup_in = '1;
        for (int k = 1; k <= 40; k++) expect_req(n + k, 1'b0, "R3 R8 R9 R7 disabled");
        repeat (40) step();
        force_wake_n = 1'b1; bod_alarm = 1'b0; rtc_alarm = 1'b0; wkup_in = '0;
        step(); step();

        // Force-wake thresholds (R3 R4 R13).
        write_cfg(mk_cfg(1, 0, 0, 3'd0, 2'd0, '0));
        src_test(0, '0, 1, 1, "R4 code0 R13");
        write_cfg(mk_cfg(1, 0, 0, 3'd1, 2'd0, '0));
        src_test(0, '0, 2, 3, "R4 code1 short");
        src_test(0, '0, 3, 3, "R4 code1");

        // Restart after a high sample (R10).
        n = cyc;
        for (int k = 1; k <= 7; k++) expect_req(n + k, 1'b0, "R10");
        force_wake_n = 1'b0; step(); step();
        force_wake_n = 1'b1; step();
        force_wake_n = 1'b0; step(); step();
        force_wake_n = 1'b1; step(); step(); step();

        // Write restarts the counter (R11).
        n = cyc;
        force_wake_n = 1'b0;
        for (int k = 1; k <= 6; k++) expect_req(n + k, 1'b0, "R11");
        expect_req(n + 7, 1'b1, "R11");
        step(); step();
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
        repeat (4) step();
        force_wake_n = 1'b1;
        step(); step();
        ack_clear("R12");

        write_cfg(mk_cfg(1, 0, 0, 3'd2, 2'd0, '0));
        src_test(0, '0, 31, 32, "R4 code2 short");
        src_test(0, '0, 32, 32, "R4 code2");
        write_cfg(mk_cfg(1, 0, 0, 3'd3, 2'd0, '0));
        src_test(0, '0, 512, 512, "R4 code3");
        write_cfg(mk_cfg(1, 0, 0, 3'd4, 2'd0, '0));
        src_test(0, '0, 4096, 4096, "R4 code4");
        write_cfg(mk_cfg(1, 0, 0, 3'd5, 2'd0, '0));
        src_test(0, '0, 32768, 32768, "R4 code5");
        write_cfg(mk_cfg(1, 0, 0, 3'd6, 2'd0, '0));
        src_test(0, '0, 32768, 32768, "R5 code6");
        write_cfg(mk_cfg(1, 0, 0, 3'd7, 2'd0, '0));
        src_test(0, '0, 4200, 32768, "R5 code7 short");

        // Brownout with re-assert after acknowledge (R8 R12).
        write_cfg(mk_cfg(0, 1, 0, 3'd0, 2'd0, '0));
        n = cyc;
        bod_alarm = 1'b1;
        expect_req(n + 1, 1'b1, "R8");
        step(); step();
        m = cyc;
        wake_ack = 1'b1;
        expect_req(m + 1, 1'b0, "R12 ack");
        expect_req(m + 2, 1'b1, "R12 reassert");
        expect_req(m + 3, 1'b1, "R12 hold");
        step();
        wake_ack = 1'b0;
        step();
        bod_alarm = 1'b0;
        step(); step();
        ack_clear("R12");

        // RTC enabled, brownout disabled (R9 R8).
        write_cfg(mk_cfg(0, 0, 1, 3'd0, 2'd0, '0));
        n = cyc;
        bod_alarm = 1'b1;
        for (int k = 1; k <= 5; k++) expect_req(n + k, 1'b0, "R8 disabled");
        repeat (5) step();
        bod_alarm = 1'b0;
        n = cyc;
        rtc_alarm = 1'b1;
        expect_req(n + 1, 1'b1, "R9");
        step();
        rtc_alarm = 1'b0;
        step(); step();
        ack_clear("R12");

        // General inputs, mask bits 3 and 4 (R6 R7).
        write_cfg(mk_cfg(0, 0, 0, 3'd0, 2'd1, 8'h18));
        n = cyc;
        for (int k = 1; k <= 10; k++) expect_req(n + k, 1'b0, "R7 per-input");
        for (int k = 0; k < 8; k++) begin
            wkup_in = (k % 2 == 0) ? 8'h08 : 8'h10;
            step();
        end
        wkup_in = '0;
        step(); step();
        src_test(1, 8'h20, 10, 11, "R7 masked");
        src_test(1, 8'h08, 3, 3, "R6 code1");
        write_cfg(mk_cfg(0, 0, 0, 3'd0, 2'd0, 8'h18));
        src_test(1, 8'h08, 1, 1, "R6 code0");
        write_cfg(mk_cfg(0, 0, 0, 3'd0, 2'd2, 8'h18));
        src_test(1, 8'h10, 31, 32, "R6 code2 short");
        src_test(1, 8'h10, 32, 32, "R6 code2");
        write_cfg(mk_cfg(0, 0, 0, 3'd0, 2'd3, 8'h18));
        src_test(1, 8'h10, 32, 32, "R6 code3");

        wait (sb_q.size() == 0);
        step(); step();
        finish_run();
    end

endmodule